// File: doc/BRIEF.md
# Programmable-Polynomial CRC Engine

This block computes a cyclic redundancy check of order 8, 16 or 32 over a byte stream that software pushes through a small register bus. Software chooses the generator polynomial, the starting value, a closing XOR mask, and whether input bytes and the finished result are bit-reversed. Input reflection and output reflection are chosen separately. The polynomial and the seed are held left-aligned in 32-bit registers, with the x^32 term implied. A lower-order code is therefore set up by shifting its polynomial to the top of the register. For example, CRC-16 with taps x^16+x^12+x^5+1 is written as 0x10210000.

One byte is absorbed per clock. Each data write folds the byte into the top of a 32-bit running remainder, and eight shift-and-conditional-XOR steps follow within that cycle. The result is formed combinationally from the remainder, so it can be read on the cycle after the last data write. It is shifted down to the active width, optionally reflected, masked with the closing XOR and returned right-justified. Rewriting the configuration leaves the running remainder alone. Only a data write or an explicit restart strobe changes it.

Top module: `crc_engine`

## Requirements
- R1: After reset, the registers read as follows: polynomial 0x04C11DB7, seed 0xFFFFFFFF, closing mask 0xFFFFFFFF, mode 3 (both reflections on), width code 2. The result register then reads 0xCBF43926 after the nine ASCII bytes "123456789".
- R2: A write with `wr_en` high stores `wdata` into the addressed register: 0 polynomial, 1 seed, 2 closing mask, 3 mode (bits [1:0] kept), 4 width code (bits [1:0] kept). A read of the same address returns the stored value, zero-extended.
- R3: A write to address 5 absorbs `wdata[7:0]` in one cycle. The byte, after any input reflection, is XORed into remainder bits [31:24]. Eight steps follow, most significant bit first, each shifting left one place and XORing in the polynomial when the bit shifted out was 1. Back-to-back writes on consecutive cycles are each absorbed.
- R4: A write to address 6 loads the remainder from the seed. Seed bits below the active width are cleared on load.
- R5: When mode bit 0 is 1, each data byte is bit-reversed before it is absorbed. When the bit is 0, the byte is used as written.
- R6: When mode bit 1 is 1, the top w bits of the remainder are bit-reversed across those w bits before the closing XOR. When the bit is 0, they are not reversed.
- R7: Width code 0 selects w=8, code 1 selects w=16, and codes 2 and 3 select w=32. The result occupies bits [w-1:0], and all higher bits read zero.
- R8: The low w bits of the closing mask are XORed into the right-justified result after any reflection.
- R9: Address 7 returns the result. A read on the cycle after a data write already reflects that byte.
- R10: Writes to addresses 0 to 4, reads, and idle cycles leave the remainder unchanged. A changed mask or mode applies to the existing remainder at once.
- R11: Reads of addresses 5 and 6 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |

## Verification
The bench aims at the width boundaries. An 8-bit code with a seed whose lower bits are set would show leftover seed bits leaking into the result if the load mask were missing. A 16-bit code would show the wrong bits being justified if the shift were off. Reflection is tested with the input and output controls set differently, which exposes a design that ties the two together or reverses all 32 bits instead of w. Rewriting the mask and mode mid-message, and checking the final value against published check values, catches a remainder that gets cleared or advanced by configuration traffic.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_POLY   = 3'd0,
    A_SEED   = 3'd1,
    A_FXOR   = 3'd2,
    A_MODE   = 3'd3,
    A_WIDTH  = 3'd4,
    A_DATA   = 3'd5,
    A_INIT   = 3'd6,
    A_RESULT = 3'd7
  } addr_e;

  // Number of unused low bits below the active CRC width.
  function automatic int unsigned width_shift(logic [CODE_W-1:0] code);
    case (code)
      2'd0:    return 24;
      2'd1:    return 16;
      default: return 0;
    endcase
  endfunction

  // Mask of the top (active) bits of the left-aligned remainder.
  function automatic logic [REG_W-1:0] top_mask(logic [CODE_W-1:0] code);
    return ~(({REG_W{1'b1}}) >> (REG_W - width_shift(code)) >> 0) & {REG_W{1'b1}};
  endfunction

  // Mask of the low (right-justified) result bits.
  function automatic logic [REG_W-1:0] low_mask(logic [CODE_W-1:0] code);
    return {REG_W{1'b1}} >> width_shift(code);
  endfunction

  function automatic logic [BYTE_W-1:0] flip_byte(logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction

  // Reverse the low w bits of v, w set by code; higher bits become zero.
  function automatic logic [REG_W-1:0] flip_low(logic [REG_W-1:0] v,
                                                logic [CODE_W-1:0] code);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W; i++) r[i] = v[REG_W-1-i];
    return r >> width_shift(code);
  endfunction

endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_eng_pkg::*;
#(
  parameter int                 W          = REG_W,
  parameter logic [REG_W-1:0]   POLY_RST   = 32'h04C1_1DB7,
  parameter logic [REG_W-1:0]   SEED_RST   = 32'hFFFF_FFFF,
  parameter logic [REG_W-1:0]   FXOR_RST   = 32'hFFFF_FFFF,
  parameter logic [1:0]         MODE_RST   = 2'b11,
  parameter logic [CODE_W-1:0]  WIDTH_RST  = 2'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      poly_o,
  output logic [W-1:0]      seed_o,
  output logic [W-1:0]      fxor_o,
  output logic              refin_o,
  output logic              refout_o,
  output logic [CODE_W-1:0] width_o,
  output logic              data_we_o,
  output logic              init_we_o,
  output logic [BYTE_W-1:0] data_byte_o
);

  addr_e sel;
  assign sel = addr_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_o   <= POLY_RST;
      seed_o   <= SEED_RST;
      fxor_o   <= FXOR_RST;
      refin_o  <= MODE_RST[0];
      refout_o <= MODE_RST[1];
      width_o  <= WIDTH_RST;
    end else if (wr_en) begin
      case (sel)
        A_POLY:  poly_o   <= wdata;
        A_SEED:  seed_o   <= wdata;
        A_FXOR:  fxor_o   <= wdata;
        A_MODE:  begin
                   refin_o  <= wdata[0];
                   refout_o <= wdata[1];
                 end
        A_WIDTH: width_o  <= wdata[CODE_W-1:0];
        default: ;
      endcase
    end
  end

  assign data_we_o = wr_en && (sel == A_DATA);
  assign init_we_o = wr_en && (sel == A_INIT);
  // Input reflection applied here so the datapath always sees MSB-first data.
  assign data_byte_o = refin_o ? flip_byte(wdata[BYTE_W-1:0]) : wdata[BYTE_W-1:0];

endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_eng_pkg::*;
#(
  parameter int W     = REG_W,
  parameter int STEPS = BYTE_W
) (
  input  logic [W-1:0]     rem_i,
  input  logic [STEPS-1:0] byte_i,
  input  logic [W-1:0]     poly_i,
  output logic [W-1:0]     rem_o
);

  logic [W-1:0] stage [0:STEPS];

  assign stage[0] = rem_i ^ {byte_i, {(W-STEPS){1'b0}}};

  for (genvar k = 0; k < STEPS; k++) begin : g_bit
    logic [W-1:0] shifted;
    assign shifted      = {stage[k][W-2:0], 1'b0};
    assign stage[k+1]   = stage[k][W-1] ? (shifted ^ poly_i) : shifted;
  end

  assign rem_o = stage[STEPS];

endmodule

// File: rtl/crc_remainder.sv
module crc_remainder
  import crc_eng_pkg::*;
#(
  parameter int               W       = REG_W,
  parameter logic [REG_W-1:0] REM_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we_i,
  input  logic              init_we_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [W-1:0]      poly_i,
  input  logic [W-1:0]      seed_i,
  input  logic [CODE_W-1:0] width_i,
  output logic [W-1:0]      rem_o
);

  logic [W-1:0] rem_q;
  logic [W-1:0] step_nxt;
  logic [W-1:0] seed_load;

  crc_byte_step #(.W(W), .STEPS(BYTE_W)) u_step (
    .rem_i  (rem_q),
    .byte_i (byte_i),
    .poly_i (poly_i),
    .rem_o  (step_nxt)
  );

  assign seed_load = seed_i & top_mask(width_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rem_q <= REM_RST;
    else if (init_we_i) rem_q <= seed_load;
    else if (data_we_i) rem_q <= step_nxt;
  end

  assign rem_o = rem_q;

  AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_we_i && !init_we_i) |=> $stable(rem_q)); // R10

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    init_we_i |=> ((rem_q & ~$past(top_mask(width_i))) == '0)); // R4

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we_i && !init_we_i && rem_q == '0 && byte_i == '0) |=> (rem_q == '0)); // R3

endmodule

// File: rtl/crc_result.sv
module crc_result
  import crc_eng_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      rem_i,
  input  logic [W-1:0]      fxor_i,
  input  logic              refout_i,
  input  logic [CODE_W-1:0] width_i,
  output logic [W-1:0]      result_o
);

  logic [W-1:0] justified;
  logic [W-1:0] oriented;

  assign justified = rem_i >> width_shift(width_i);
  assign oriented  = refout_i ? flip_low(justified, width_i) : justified;
  assign result_o  = (oriented ^ fxor_i) & low_mask(width_i);

  AST_NARROW_8: assert property (@(posedge clk) disable iff (!rst_n)
    (width_i == 2'd0) |-> (result_o[W-1:8] == '0)); // R7

  AST_NARROW_16: assert property (@(posedge clk) disable iff (!rst_n)
    (width_i == 2'd1) |-> (result_o[W-1:16] == '0)); // R7

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata
);

  localparam int W = REG_W;

  logic [W-1:0]      poly, seed, fxor, rem, result;
  logic              refin, refout, data_we, init_we;
  logic [CODE_W-1:0] width_code;
  logic [BYTE_W-1:0] data_byte;

  crc_cfg_regs #(.W(W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .poly_o      (poly),
    .seed_o      (seed),
    .fxor_o      (fxor),
    .refin_o     (refin),
    .refout_o    (refout),
    .width_o     (width_code),
    .data_we_o   (data_we),
    .init_we_o   (init_we),
    .data_byte_o (data_byte)
  );

  crc_remainder #(.W(W)) u_rem (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_we_i (data_we),
    .init_we_i (init_we),
    .byte_i    (data_byte),
    .poly_i    (poly),
    .seed_i    (seed),
    .width_i   (width_code),
    .rem_o     (rem)
  );

  crc_result #(.W(W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .rem_i    (rem),
    .fxor_i   (fxor),
    .refout_i (refout),
    .width_i  (width_code),
    .result_o (result)
  );

  always_comb begin
    case (addr_e'(addr))
      A_POLY:   rdata = poly;
      A_SEED:   rdata = seed;
      A_FXOR:   rdata = fxor;
      A_MODE:   rdata = {{(W-2){1'b0}}, refout, refin};
      A_WIDTH:  rdata = {{(W-CODE_W){1'b0}}, width_code};
      A_RESULT: rdata = result;
      default:  rdata = '0; // R11
    endcase
  end

endmodule

// File: tb/crc_engine_bench.sv
`timescale 1ns/1ps
module crc_engine_bench;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  // Bench-side model state (right-justified, own bitwise algorithm)
  int          m_w = 32;
  logic [31:0] m_poly = 32'h04C11DB7, m_seed = 32'hFFFFFFFF, m_fxor = 32'hFFFFFFFF;
  logic        m_refin = 1'b1, m_refout = 1'b1;
  logic [31:0] m_rem = 32'hFFFFFFFF;

  always #(CLK_P/2) clk = ~clk;

  crc_engine u_crc_engine (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
                           .addr(addr), .wdata(wdata), .rdata(rdata));

  function automatic logic [31:0] wmask(int w);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] m_result();
    logic [31:0] r = 32'd0;
    if (m_refout) begin
      for (int i = 0; i < m_w; i++) r[i] = m_rem[m_w-1-i];
    end else r = m_rem;
    return (r ^ m_fxor) & wmask(m_w);
  endfunction

  task automatic m_feed(input logic [7:0] b);
    logic [7:0] d = b;
    if (m_refin) for (int i = 0; i < 8; i++) d[i] = b[7-i];
    for (int i = 7; i >= 0; i--) begin
      logic fb = m_rem[m_w-1] ^ d[i];
      m_rem = (m_rem << 1) & wmask(m_w);
      if (fb) m_rem = m_rem ^ m_poly;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // Program the engine and the model together. width code: 0/1/2 -> 8/16/32.
  task automatic setup(input logic [31:0] poly, input logic [31:0] seed,
                       input logic [31:0] fx, input logic [1:0] mode, input logic [1:0] code);
    int w = (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
    wr(3'd0, poly); wr(3'd1, seed); wr(3'd2, fx); wr(3'd3, {30'd0, mode}); wr(3'd4, {30'd0, code});
    m_w = w; m_poly = poly >> (32 - w); m_seed = seed >> (32 - w);
    m_fxor = fx; m_refin = mode[0]; m_refout = mode[1];
  endtask

  task automatic restart();
    wr(3'd6, 32'd0);
    m_rem = m_seed;
  endtask

  // Back-to-back byte stream, one per cycle
  task automatic feed_str(input string s);
    @(negedge clk);
    for (int i = 0; i < s.len(); i++) begin
      wr_en = 1'b1; addr = 3'd5; wdata = {24'd0, s[i]};
      m_feed(s[i]);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 poly reset", v, 32'h04C11DB7);
    rd(3'd1, v); chk("R1 seed reset", v, 32'hFFFFFFFF);
    rd(3'd2, v); chk("R1 mask reset", v, 32'hFFFFFFFF);
    rd(3'd3, v); chk("R1 mode reset", v, 32'd3);
    rd(3'd4, v); chk("R1 width reset", v, 32'd2);
    rd(3'd5, v); chk("R11 data addr read", v, 32'd0);
    rd(3'd6, v); chk("R11 init addr read", v, 32'd0);
    feed_str("123456789");
    rd(3'd7, v); chk("R1 reset CRC-32 check", v, 32'hCBF43926);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd0, 32'hA5A5_0F0F); rd(3'd0, v); chk("R2 poly rw", v, 32'hA5A5_0F0F);
    wr(3'd1, 32'h1234_5678); rd(3'd1, v); chk("R2 seed rw", v, 32'h1234_5678);
    wr(3'd2, 32'hDEAD_BEEF); rd(3'd2, v); chk("R2 mask rw", v, 32'hDEAD_BEEF);
    wr(3'd3, 32'hFFFF_FFFE); rd(3'd3, v); chk("R2 mode rw", v, 32'd2);
    wr(3'd4, 32'hFFFF_FFFD); rd(3'd4, v); chk("R2 width rw", v, 32'd1);
  endtask

  task automatic t_crc32();
    logic [31:0] v;
    setup(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b11, 2'd2);
    restart();
    feed_str("123456789");
    rd(3'd7, v); chk("R9 crc32 next-cycle read", v, 32'hCBF43926);
    chk("R3 crc32 model", v, m_result());
  endtask

  task automatic t_crc16();
    logic [31:0] v;
    setup(32'h10210000, 32'hFFFF0000, 32'h0, 2'b00, 2'd1);
    restart();
    feed_str("123456789");
    rd(3'd7, v); chk("R7 crc16 check", v, 32'h000029B1);
    chk("R3 crc16 model", v, m_result());
  endtask

  task automatic t_crc8();
    logic [31:0] v;
    setup(32'h31000000, 32'h0, 32'h0, 2'b11, 2'd0);
    restart();
    feed_str("123456789");
    rd(3'd7, v); chk("R6 crc8 reflected check", v, 32'h000000A1);
    chk("R5 crc8 model", v, m_result());
  endtask

  task automatic t_seed_mask();
    logic [31:0] v;
    setup(32'h31000000, 32'h12ABCDEF, 32'h0, 2'b00, 2'd0);
    restart();
    rd(3'd7, v); chk("R4 seed top bits only", v, 32'h00000012);
    feed_str("\000\000");
    rd(3'd7, v); chk("R4 seed low bits cleared", v, m_result());
    setup(32'h31000000, 32'h12ABCDEF, 32'hFFFFFFFF, 2'b00, 2'd0);
    rd(3'd7, v); chk("R8 mask low bits only", v, m_result());
  endtask

  task automatic t_split_reflect();
    logic [31:0] v;
    setup(32'h04C11DB7, 32'hFFFFFFFF, 32'h0, 2'b01, 2'd2);
    restart();
    feed_str("\x81\x03\xF0\x5A");
    rd(3'd7, v); chk("R5 refin only", v, m_result());
    setup(32'h10210000, 32'h1D0F0000, 32'h0000A5A5, 2'b10, 2'd1);
    restart();
    feed_str("\x81\x03\xF0\x5A");
    rd(3'd7, v); chk("R6 refout only 16", v, m_result());
  endtask

  task automatic t_no_disturb();
    logic [31:0] v;
    setup(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b11, 2'd2);
    restart();
    feed_str("1234");
    wr(3'd2, 32'h0); m_fxor = 32'h0;
    rd(3'd7, v); chk("R10 new mask on live remainder", v, m_result());
    wr(3'd3, 32'd1); m_refout = 1'b0;
    rd(3'd7, v); chk("R10 new mode on live remainder", v, m_result());
    repeat (5) @(negedge clk);
    rd(3'd7, v); chk("R10 idle hold", v, m_result());
    wr(3'd3, 32'd3); wr(3'd2, 32'hFFFFFFFF); wr(3'd0, 32'h04C11DB7); wr(3'd1, 32'h0);
    m_refout = 1'b1; m_fxor = 32'hFFFFFFFF;
    feed_str("56789");
    rd(3'd7, v); chk("R10 resumed stream check", v, 32'hCBF43926);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_crc32();
    t_crc16();
    t_crc8();
    t_seed_mask();
    t_split_reflect();
    t_no_disturb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule